// File: doc/BRIEF.md
# Trigger Command Word Decoder and Readout Sequencer

This block sits at the receiving end of a trigger supervisor's command link. It takes one 9-bit word on each cycle where `cmd_valid` is high. It sorts the word into one of four kinds using its two lowest bits and decodes the fields of that kind. It then raises the matching pulses and level outputs toward the readout electronics. It also drives three status lines back to the supervisor: done, error and wait.

Level 1 accepts are forwarded in the cycle after they arrive. The buffer address of each accept goes into a small queue. A readout command is issued from the head of that queue only when the downstream readout reports done. After a readout command is issued, the next one waits until the readout-done input has fallen and then risen again.

Control words handle several functions:
- halt, reset and run;
- a two-step test toggle that drives the status lines to a fixed pattern;
- scan-list selection;
- arming of the pipeline fill, which starts on the next bunch-zero pulse.

Top module: `trig_cmd_seq`

## Requirements
- R1: A word with bits 1:0 = 00 and bit 2 set is a Level 1 accept. It raises `l1a_fwd` for one cycle, in the cycle after the word. In that same cycle, `store_id` = {bit 6, bits 5:4}. If bit 2 is clear, no pulse is made, even when the reject bit 3 is set. Bits 8:7 have no effect.
- R2: If the queue is empty and `readout_done` is high, `readout_cmd` pulses one cycle after `l1a_fwd`, with `readout_buf` = the buffer address of that accept.
- R3: Readout commands leave in arrival order. After a readout command, the next one is issued only once `readout_done` has been seen low and then high again.
- R4: Up to 4 accepts can wait in the queue. From the cycle after the fourth is stored, `sup_wait` is high. An accept that arrives while the queue is full is still forwarded on `l1a_fwd`, but it is dropped from the queue and it sets `sup_error`. That error stays set until a reset control word.
- R5: A word with bits 1:0 = 10 (bit 1 set, bit 0 clear) is a start-event-scan. The next cycle, it pulses `scan_start`, sets `scan_buf` = bits 3:2 and `scan_evid` = bits 8:5, and drives `sup_done` low.
- R6: `sup_done` returns high in the cycle after the queue is empty and no readout is in progress. While accepts are pending, it stays low.
- R7: A word with bits 1:0 = 01 is a calibration word. The next cycle, it pulses `calib_pulse` with `calib_action` = bits 4:2 (000 scope, 001 injection, 010 laser). Code 111 makes no pulse and leaves `calib_action` unchanged.
- R8: A word with bits 1:0 = 11 is a control word. When its bit 4 (test) is set, it toggles a test state. Entering that state gives `sup_done`=0, `sup_error`=1, `sup_wait`=1. Leaving it gives `sup_done`=1, `sup_error`=0, `sup_wait`=0. Each change appears in the cycle after the word.
- R9: `scan_list` takes bits 8:6 of a control word only when bits 5:2 of that word are all zero. Otherwise `scan_list` holds its value.
- R10: Control bit 5 (run) sets `run_armed` and clears `halt_out`. The first `bunch_zero` seen while armed sets `pipe_fill` and clears `run_armed` in the next cycle. Control bit 2 (halt) sets `halt_out` and clears both `run_armed` and `pipe_fill`. Halt wins over run.
- R11: Control bit 3 (reset) empties the queue, drops queued readouts, and clears the overflow error, the test state, `run_armed`, `pipe_fill` and `halt_out`. In the next cycle `sup_done`=1, `sup_error`=0 and `sup_wait`=0.
- R12: `sync_lost` high makes `sup_error` high in the next cycle.
- R13: After `rst`, `sup_done`=1, `sup_error`=0, `sup_wait`=0, and every pulse output, `scan_list`, `run_armed` and `pipe_fill` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 9 | Command word from the supervisor |
| bunch_zero | input | 1 | Once-per-revolution pulse |
| readout_done | input | 1 | High when downstream readout is finished |
| sync_lost | input | 1 | Downstream loss of link synchronization |
| l1a_fwd | output | 1 | Forwarded Level 1 accept pulse |
| store_id | output | 3 | Low bits of the store-buffer ID |
| readout_cmd | output | 1 | Read/digitize/readout command pulse |
| readout_buf | output | 2 | Buffer address for the readout command |
| scan_start | output | 1 | Start-event-scan pulse |
| scan_buf | output | 2 | Buffer address from the scan word |
| scan_evid | output | 4 | Event ID from the scan word |
| calib_pulse | output | 1 | Calibration action pulse |
| calib_action | output | 3 | Calibration action code |
| halt_out | output | 1 | Input to the pipeline is halted |
| run_armed | output | 1 | Waiting for bunch zero to start filling |
| pipe_fill | output | 1 | Pipeline filling enabled |
| scan_list | output | 3 | Selected scan list |
| sup_done | output | 1 | Done status to the supervisor |
| sup_error | output | 1 | Error status to the supervisor |
| sup_wait | output | 1 | Wait status to the supervisor |

## Verification
Some internal faults show only on the status lines, and usually within two cycles. A queue count that is off by one can raise `sup_wait` one accept early, let a fifth accept through without an error, or leave `sup_done` low after the queue drains. A readout gate in the wrong state can issue `readout_cmd` while `readout_done` is low, or miss the low phase it must wait for. Either fault appears on the next command, and a scoreboard of expected buffer addresses catches it in arrival order. A wrong test or overflow flag shows at once as the wrong done/error/wait pattern.

// File: rtl/trig_cmd_pkg.sv
package trig_cmd_pkg;
  localparam int CMD_W  = 9;
  localparam int BUF_W  = 2;
  localparam int EVID_W = 4;
  localparam int CAL_W  = 3;
  localparam int SCAN_W = 3;
  localparam int SID_W  = BUF_W + 1;

  // word kind taken straight from bits 1:0
  typedef enum logic [1:0] {
    K_L1   = 2'b00,
    K_CAL  = 2'b01,
    K_SES  = 2'b10,
    K_CTRL = 2'b11
  } kind_e;

  localparam logic [CAL_W-1:0] CAL_IDLE = 3'b111;

  typedef enum logic [1:0] {
    G_IDLE  = 2'd0,
    G_WLOW  = 2'd1,
    G_WHIGH = 2'd2
  } gate_e;

  typedef struct packed {
    logic              accept;
    logic [BUF_W-1:0]  l1_buf;
    logic              l1_spare;
    logic              ses;
    logic [BUF_W-1:0]  ses_buf;
    logic [EVID_W-1:0] evid;
    logic              cal;
    logic [CAL_W-1:0]  cal_code;
    logic              halt;
    logic              clr;
    logic              test;
    logic              run;
    logic              scan_upd;
    logic [SCAN_W-1:0] scan_sel;
  } dec_t;
endpackage

// File: rtl/trig_word_decode.sv
module trig_word_decode
  import trig_cmd_pkg::*;
(
  input  logic             valid,
  input  logic [CMD_W-1:0] word,
  output dec_t             d
);
  kind_e kind;

  always_comb begin
    kind = kind_e'(word[1:0]);
    d    = '0;
    if (valid) begin
      unique case (kind)
        K_L1: begin
          d.accept   = word[2];
          d.l1_buf   = word[5:4];
          d.l1_spare = word[6] & word[2];
        end
        K_SES: begin
          d.ses     = 1'b1;
          d.ses_buf = word[3:2];
          d.evid    = word[8:5];
        end
        K_CAL: begin
          d.cal_code = word[4:2];
          d.cal      = (word[4:2] != CAL_IDLE);
        end
        K_CTRL: begin
          d.halt     = word[2];
          d.clr      = word[3];
          d.test     = word[4];
          d.run      = word[5];
          d.scan_upd = (word[5:2] == 4'b0000);
          d.scan_sel = word[8:6];
        end
        default: d = '0;
      endcase
    end
  end
endmodule

// File: rtl/cmd_fifo.sv
module cmd_fifo #(
  parameter int W     = 2,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   CAP  = (AW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic push_ok, pop_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CAP);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      cnt <= cnt + {{AW{1'b0}}, push_ok} - {{AW{1'b0}}, pop_ok};
    end
  end
endmodule

// File: rtl/readout_gate.sv
module readout_gate
  import trig_cmd_pkg::*;
#(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         q_empty,
  input  logic [W-1:0] q_data,
  input  logic         ro_done,
  output logic         q_pop,
  output logic         cmd_pulse,
  output logic [W-1:0] cmd_buf,
  output logic         idle
);
  gate_e st;

  assign idle  = (st == G_IDLE);
  assign q_pop = idle && !q_empty && ro_done && !flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= G_IDLE;
      cmd_pulse <= 1'b0;
      cmd_buf   <= '0;
    end else if (flush) begin
      st        <= G_IDLE;
      cmd_pulse <= 1'b0;
    end else begin
      cmd_pulse <= q_pop;
      if (q_pop) cmd_buf <= q_data;
      unique case (st)
        G_IDLE:  if (q_pop)    st <= G_WLOW;
        G_WLOW:  if (!ro_done) st <= G_WHIGH;
        G_WHIGH: if (ro_done)  st <= G_IDLE;
        default: st <= G_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/link_status.sv
module link_status (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic ses,
  input  logic test,
  input  logic ovf_evt,
  input  logic sync_lost,
  input  logic drained,
  input  logic q_full,
  output logic done_o,
  output logic error_o,
  output logic wait_o
);
  logic done_r, test_r, ovf_r;
  logic n_done, n_test, n_ovf;

  always_comb begin
    n_done = clr ? 1'b1 : ses ? 1'b0 : drained ? 1'b1 : done_r;
    n_test = clr ? 1'b0 : (test ? ~test_r : test_r);
    n_ovf  = clr ? 1'b0 : (ovf_r | ovf_evt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_r  <= 1'b1;
      test_r  <= 1'b0;
      ovf_r   <= 1'b0;
      done_o  <= 1'b1;
      error_o <= 1'b0;
      wait_o  <= 1'b0;
    end else begin
      done_r  <= n_done;
      test_r  <= n_test;
      ovf_r   <= n_ovf;
      done_o  <= n_done & ~n_test;
      error_o <= n_ovf | n_test | sync_lost;
      wait_o  <= n_test | (q_full & ~clr);
    end
  end
endmodule

// File: rtl/trig_cmd_seq.sv
module trig_cmd_seq
  import trig_cmd_pkg::*;
#(
  parameter int Q_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              bunch_zero,
  input  logic              readout_done,
  input  logic              sync_lost,
  output logic              l1a_fwd,
  output logic [SID_W-1:0]  store_id,
  output logic              readout_cmd,
  output logic [BUF_W-1:0]  readout_buf,
  output logic              scan_start,
  output logic [BUF_W-1:0]  scan_buf,
  output logic [EVID_W-1:0] scan_evid,
  output logic              calib_pulse,
  output logic [CAL_W-1:0]  calib_action,
  output logic              halt_out,
  output logic              run_armed,
  output logic              pipe_fill,
  output logic [SCAN_W-1:0] scan_list,
  output logic              sup_done,
  output logic              sup_error,
  output logic              sup_wait
);
  dec_t             d;
  logic             q_empty, q_full, q_pop, g_idle;
  logic [BUF_W-1:0] q_data;

  trig_word_decode u_dec (
    .valid (cmd_valid),
    .word  (cmd_word),
    .d     (d)
  );

  cmd_fifo #(.W(BUF_W), .DEPTH(Q_DEPTH)) u_q (
    .clk   (clk),
    .rst   (rst),
    .flush (d.clr),
    .push  (d.accept),
    .din   (d.l1_buf),
    .pop   (q_pop),
    .dout  (q_data),
    .empty (q_empty),
    .full  (q_full)
  );

  readout_gate #(.W(BUF_W)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .flush     (d.clr),
    .q_empty   (q_empty),
    .q_data    (q_data),
    .ro_done   (readout_done),
    .q_pop     (q_pop),
    .cmd_pulse (readout_cmd),
    .cmd_buf   (readout_buf),
    .idle      (g_idle)
  );

  link_status u_stat (
    .clk       (clk),
    .rst       (rst),
    .clr       (d.clr),
    .ses       (d.ses),
    .test      (d.test),
    .ovf_evt   (d.accept & q_full & ~q_pop),
    .sync_lost (sync_lost),
    .drained   (q_empty & g_idle),
    .q_full    (q_full),
    .done_o    (sup_done),
    .error_o   (sup_error),
    .wait_o    (sup_wait)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      l1a_fwd      <= 1'b0;
      store_id     <= '0;
      scan_start   <= 1'b0;
      scan_buf     <= '0;
      scan_evid    <= '0;
      calib_pulse  <= 1'b0;
      calib_action <= '0;
      scan_list    <= '0;
      run_armed    <= 1'b0;
      pipe_fill    <= 1'b0;
      halt_out     <= 1'b0;
    end else begin
      l1a_fwd <= d.accept;
      if (d.accept) store_id <= {d.l1_spare, d.l1_buf};
      scan_start <= d.ses;
      if (d.ses) begin
        scan_buf  <= d.ses_buf;
        scan_evid <= d.evid;
      end
      calib_pulse <= d.cal;
      if (d.cal) calib_action <= d.cal_code;
      if (d.scan_upd) scan_list <= d.scan_sel;
      if (bunch_zero && run_armed) begin
        pipe_fill <= 1'b1;
        run_armed <= 1'b0;
      end
      if (d.clr) begin
        run_armed <= 1'b0;
        pipe_fill <= 1'b0;
        halt_out  <= 1'b0;
      end else if (d.halt) begin
        halt_out  <= 1'b1;
        run_armed <= 1'b0;
        pipe_fill <= 1'b0;
      end else if (d.run) begin
        run_armed <= 1'b1;
        halt_out  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/trig_cmd_seq_chk.sv
module trig_cmd_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [8:0] cmd_word,
  input logic       bunch_zero,
  input logic       readout_done,
  input logic       sync_lost,
  input logic       l1a_fwd,
  input logic       readout_cmd,
  input logic       calib_pulse,
  input logic       pipe_fill,
  input logic [2:0] scan_list,
  input logic       sup_done,
  input logic       sup_error,
  input logic       sup_wait
);
  logic rst_q = 1'b0;
  logic pend, seen_low;
  logic reset_word;

  assign reset_word = cmd_valid && (cmd_word[1:0] == 2'b11) && cmd_word[3];

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q && !rst)
      a_reset_state_r13: assert (sup_done && !sup_error && !sup_wait);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      seen_low <= 1'b0;
    end else if (reset_word) begin
      pend     <= 1'b0;
      seen_low <= 1'b0;
    end else if (readout_cmd) begin
      pend     <= 1'b1;
      seen_low <= !readout_done;
    end else if (pend && !readout_done) begin
      seen_low <= 1'b1;
    end else if (pend && seen_low && readout_done) begin
      pend <= 1'b0;
    end
  end

  p_l1a_fwd_r1: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_word[1:0] == 2'b00 && cmd_word[2]) |=> l1a_fwd);

  p_cmd_needs_done_r2: assert property (@(posedge clk) disable iff (rst)
    readout_cmd |-> $past(readout_done));

  p_cmd_handshake_r3: assert property (@(posedge clk) disable iff (rst)
    readout_cmd |-> !pend);

  p_cal_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_word[1:0] == 2'b01 && cmd_word[4:2] == 3'b111) |=> !calib_pulse);

  p_scan_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_word[1:0] == 2'b11 && cmd_word[5:2] != 4'b0000) |=> $stable(scan_list));

  p_fill_on_bz_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(pipe_fill) |-> $past(bunch_zero));

  p_sync_err_r12: assert property (@(posedge clk) disable iff (rst)
    sync_lost |=> sup_error);
endmodule

bind trig_cmd_seq trig_cmd_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_valid    (cmd_valid),
  .cmd_word     (cmd_word),
  .bunch_zero   (bunch_zero),
  .readout_done (readout_done),
  .sync_lost    (sync_lost),
  .l1a_fwd      (l1a_fwd),
  .readout_cmd  (readout_cmd),
  .calib_pulse  (calib_pulse),
  .pipe_fill    (pipe_fill),
  .scan_list    (scan_list),
  .sup_done     (sup_done),
  .sup_error    (sup_error),
  .sup_wait     (sup_wait)
);

// File: tb/sim_trig_cmd_seq.sv
module sim_trig_cmd_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [8:0] cmd_word = '0;
  logic       bunch_zero = 1'b0;
  logic       readout_done = 1'b1;
  logic       sync_lost = 1'b0;
  logic       l1a_fwd, readout_cmd, scan_start, calib_pulse;
  logic       halt_out, run_armed, pipe_fill, sup_done, sup_error, sup_wait;
  logic [2:0] store_id, calib_action, scan_list;
  logic [1:0] readout_buf, scan_buf;
  logic [3:0] scan_evid;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_q[$];
  bit auto_ro = 1'b0;
  bit manual_done = 1'b1;
  int ro_cnt = 0;
  bit finished = 1'b0;
  bit saw_low = 1'b0;
  bit had_prev = 1'b0;

  always #10 clk = ~clk;

  trig_cmd_seq u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .bunch_zero(bunch_zero), .readout_done(readout_done), .sync_lost(sync_lost),
    .l1a_fwd(l1a_fwd), .store_id(store_id), .readout_cmd(readout_cmd),
    .readout_buf(readout_buf), .scan_start(scan_start), .scan_buf(scan_buf),
    .scan_evid(scan_evid), .calib_pulse(calib_pulse), .calib_action(calib_action),
    .halt_out(halt_out), .run_armed(run_armed), .pipe_fill(pipe_fill),
    .scan_list(scan_list), .sup_done(sup_done), .sup_error(sup_error),
    .sup_wait(sup_wait)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(logic [8:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = '0;
  endtask

  // driver side of the scoreboard: an accept with its expected readout
  task automatic accept(logic [8:0] w, bit queued);
    if (queued) exp_q.push_back(int'(w[5:4]));
    send(w);
  endtask

  // downstream readout model
  always @(negedge clk) begin
    if (auto_ro) begin
      if (readout_cmd === 1'b1) ro_cnt = 3;
      if (ro_cnt > 0) begin
        readout_done = 1'b0;
        ro_cnt--;
      end else begin
        readout_done = 1'b1;
      end
    end else begin
      readout_done = manual_done;
    end
  end

  always @(posedge clk) if (readout_done == 1'b0) saw_low = 1'b1;

  // monitor: pops expected buffer addresses as readout commands appear
  always @(negedge clk) begin
    if (!rst && readout_cmd === 1'b1) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R3: actual readout_cmd buf %0d expected no command", readout_buf);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(readout_buf) != e) begin
          n_fail++;
          $display("FAIL R3: actual readout_buf %0d expected %0d", readout_buf, e);
        end
      end
      if (had_prev && !saw_low) begin
        n_fail++;
        $display("FAIL R3: actual command without done low phase expected low then high");
      end
      saw_low  = 1'b0;
      had_prev = 1'b1;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R13 reset state
    chk("R13 done", sup_done, 1);
    chk("R13 error", sup_error, 0);
    chk("R13 wait", sup_wait, 0);
    chk("R13 pulses", {l1a_fwd, readout_cmd, scan_start, calib_pulse}, 0);
    chk("R13 levels", {scan_list, run_armed, pipe_fill}, 0);

    auto_ro = 1'b1;
    repeat (3) @(negedge clk);
    // R1 accept with reserved bit, R2 readout one cycle later
    accept(9'h064, 1'b1);
    chk("R1 l1a_fwd", l1a_fwd, 1);
    chk("R1 store_id", store_id, 3'b110);
    @(negedge clk);
    chk("R2 readout_cmd", readout_cmd, 1);
    chk("R2 readout_buf", readout_buf, 2);
    repeat (10) @(negedge clk);
    // R1 reject only, then spare bits set with accept
    send(9'h008);
    chk("R1 reject no forward", l1a_fwd, 0);
    accept(9'h184, 1'b1);
    chk("R1 spare ignored", {l1a_fwd, store_id}, 4'b1000);
    repeat (10) @(negedge clk);

    // R3 back to back accepts
    accept(9'h004, 1'b1);
    accept(9'h014, 1'b1);
    accept(9'h034, 1'b1);
    repeat (40) @(negedge clk);
    chk("R3 all issued", exp_q.size(), 0);
    chk("R6 done after drain", sup_done, 1);

    // R5 scan word, R6 immediate return
    send(9'h146);
    chk("R5 scan_start", scan_start, 1);
    chk("R5 scan_buf", scan_buf, 1);
    chk("R5 scan_evid", scan_evid, 4'hA);
    chk("R5 done low", sup_done, 0);
    @(negedge clk);
    chk("R6 done back", sup_done, 1);

    // R6 done held while an accept is pending
    auto_ro = 1'b0; manual_done = 1'b0;
    repeat (2) @(negedge clk);
    accept(9'h024, 1'b1);
    send(9'h002);
    chk("R6 done low on scan", sup_done, 0);
    repeat (5) @(negedge clk);
    chk("R6 done held", sup_done, 0);
    auto_ro = 1'b1;
    repeat (20) @(negedge clk);
    chk("R6 done after readout", sup_done, 1);
    chk("R6 queue drained", exp_q.size(), 0);

    // R4 overflow
    auto_ro = 1'b0; manual_done = 1'b0;
    repeat (2) @(negedge clk);
    accept(9'h004, 1'b1);
    accept(9'h014, 1'b1);
    accept(9'h024, 1'b1);
    accept(9'h034, 1'b1);
    @(negedge clk);
    chk("R4 wait when full", sup_wait, 1);
    chk("R4 no error yet", sup_error, 0);
    accept(9'h014, 1'b0);
    chk("R4 overflow still forwarded", l1a_fwd, 1);
    chk("R4 overflow error", sup_error, 1);
    auto_ro = 1'b1;
    repeat (60) @(negedge clk);
    chk("R4 four issued", exp_q.size(), 0);
    chk("R4 error sticky", sup_error, 1);
    chk("R4 wait cleared", sup_wait, 0);
    send(9'h00B);
    chk("R11 error cleared", sup_error, 0);
    chk("R11 done", sup_done, 1);

    // R11 reset drops queue, test state and arming
    auto_ro = 1'b0; manual_done = 1'b0;
    repeat (2) @(negedge clk);
    accept(9'h004, 1'b0);
    accept(9'h014, 1'b0);
    send(9'h023);
    chk("R10 armed by run", run_armed, 1);
    send(9'h013);
    chk("R8 test entered", {sup_done, sup_error, sup_wait}, 3'b011);
    send(9'h00B);
    chk("R11 status", {sup_done, sup_error, sup_wait}, 3'b100);
    chk("R11 disarmed", {run_armed, pipe_fill, halt_out}, 0);
    auto_ro = 1'b1;
    repeat (20) @(negedge clk);
    chk("R11 no readout after reset", exp_q.size(), 0);

    // R8 test toggle
    send(9'h013);
    chk("R8 first test", {sup_done, sup_error, sup_wait}, 3'b011);
    send(9'h013);
    chk("R8 second test", {sup_done, sup_error, sup_wait}, 3'b100);

    // R9 scan list
    send(9'h143);
    chk("R9 scan list set", scan_list, 5);
    send(9'h0A3);
    chk("R9 scan list held", scan_list, 5);
    chk("R10 armed", run_armed, 1);
    chk("R10 not filling yet", pipe_fill, 0);

    // R10 bunch zero and halt
    @(negedge clk); bunch_zero = 1'b1;
    @(negedge clk); bunch_zero = 1'b0;
    chk("R10 fill on bunch zero", {pipe_fill, run_armed}, 2'b10);
    send(9'h007);
    chk("R10 halt", {pipe_fill, halt_out, run_armed}, 3'b010);
    @(negedge clk); bunch_zero = 1'b1;
    @(negedge clk); bunch_zero = 1'b0;
    chk("R10 bunch zero unarmed", pipe_fill, 0);

    // R7 calibration
    send(9'h005);
    chk("R7 injection", {calib_pulse, calib_action}, 4'b1001);
    send(9'h01D);
    chk("R7 no action", {calib_pulse, calib_action}, 4'b0001);
    send(9'h009);
    chk("R7 laser", {calib_pulse, calib_action}, 4'b1010);

    // R12 sync loss
    @(negedge clk); sync_lost = 1'b1;
    @(negedge clk);
    chk("R12 error on sync loss", sup_error, 1);
    sync_lost = 1'b0;
    @(negedge clk);
    chk("R12 error follows", sup_error, 0);

    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule